// File: doc/BRIEF.md
# Squaring Baud Clock Recovery Loop

This block pulls a symbol-rate clock out of a baseband data stream that has already been brought to zero frequency by a carrier tracker. It squares each data sample, which turns a data stream with a transition in every bit into a spectral line at the clock rate. It keeps a running estimate of that line's mean level and removes it. The centred tone is then mixed with a locally generated cosine taken from a clock-phase accumulator. A 13-tap lowpass filter smooths the mixer output into a phase error.

A slowly leaking integrator plus a small proportional term turns the error into a phase correction. The accumulator adds that correction and a nominal increment on every sample. Each time the accumulator passes one full turn (16384 counts), the block raises a one-cycle baud strobe. The filter's delay line is brought out in full, so that a downstream bit slicer can correlate against the samples around the strobe.

Samples arrive with a valid qualifier. All state advances only on qualified cycles.

Top module: `baud_clock_recovery`

## Requirements
- R1: While reset is held and for the cycles right after it, the clock phase reads 0, the strobe is low and all thirteen delay-line taps read 0. The reset is asserted asynchronously and released through a two-stage synchroniser.
- R2: On a cycle with `smp_vld` low, the phase, the delay line and the internal averages keep their values, whatever `smp_data` holds, and the strobe is low the next cycle.
- R3: For a qualified sample d (signed 16-bit), the squared tone is t = min(32767, floor(3·d²/2^15)). For example, d = -32768 gives 32767.
- R4: The mean level updates as a' = floor((7·a + t)/8), starting from 0. The centred tone is c = 4·(t − a'), using the updated mean.
- R5: The reference is an approximate cosine of the current phase p, before the update. Take s = (p mod 16384 + 4096) mod 16384 and h = s mod 8192. Then m = min(32767, floor(h·(8192−h)/2^9)), and the reference is −m when s ≥ 8192, otherwise m.
- R6: The mixer output x = floor(c·ref/2^15), saturated to [−32768, 32767], enters tap 0. Tap k moves to tap k+1. Tap k appears on `err_taps[16k+15:16k]`, two's complement.
- R7: The phase error is e = floor(Σ C[k]·tap[k] / 2^15), taken over the updated delay line. The coefficients are C = −930, −293, 732, 2571, 4769, 6557, 7249, 6557, 4769, 2571, 732, −293, −930 (symmetric).
- R8: The integrator updates as i' = floor((15·i + floor(e/2))/16), starting from 0, which is 15/16 decay plus 1/32 of the error. The correction is floor(e/64) + floor(i'/2).
- R9: The new phase is q = p + correction + 1638. If q ≥ 16384, the phase becomes q − 16384 and `baud_stb` is high for exactly the following cycle. If q < −16384, the phase is held at −16384. Otherwise the phase becomes q. With zero input from reset, the eleventh sample wraps and leaves the phase at 1634.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Qualifies `smp_data` for this cycle |
| smp_data | input | 16 | Signed baseband data sample |
| baud_stb | output | 1 | One-cycle pulse when the clock phase completes a turn |
| clk_phase | output | 16 | Signed clock-phase accumulator, 16384 counts per turn |
| err_taps | output | 208 | Delay line of mixer outputs, 13 signed 16-bit taps, tap 0 in the low bits |

## Verification
The bench builds the block with its default parameters: 16-bit samples, a 16-bit phase, a 14-bit turn and an increment of 1638. With these values the phase wraps roughly every ten qualified samples, so a few thousand samples produce hundreds of strobes and many wraps that are shifted by the correction. Full-scale inputs of both signs reach the squaring saturation and the mixer clamp. Random gaps in `smp_vld` exercise the hold behaviour in the middle of the loop's transient.

// File: rtl/clkrec_pkg.sv
package clkrec_pkg;
  // number of taps in the phase-error lowpass
  localparam int NTAP = 13;
  // symmetric lowpass coefficients, oldest tap last
  localparam int signed FIR_C [NTAP] = '{
    -930, -293, 732, 2571, 4769, 6557, 7249, 6557, 4769, 2571, 732, -293, -930
  };
endpackage

// File: rtl/clkrec_square_dc.sv
module clkrec_square_dc #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW+2:0] dc_out
);
  localparam int PW = 2*DW + 2;
  localparam int AW = DW + 4;
  localparam logic signed [PW-1:0] TOP = PW'(2**(DW-1) - 1);

  logic signed [PW-1:0] sq_w;
  logic signed [PW-1:0] tone_w;
  logic signed [DW-1:0] tone;
  logic signed [AW-1:0] avg_sum;
  logic signed [DW-1:0] avg_d;
  logic signed [DW-1:0] avg_q;

  always_comb begin
    sq_w    = PW'(din) * PW'(din);
    tone_w  = (sq_w * PW'(3)) >>> (DW-1);
    tone    = (tone_w > TOP) ? DW'(TOP) : DW'(tone_w);
    avg_sum = AW'(avg_q) * AW'(7) + AW'(tone);
    avg_d   = DW'(avg_sum >>> 3);
    dc_out  = ((DW+3)'(tone) - (DW+3)'(avg_d)) * (DW+3)'(4);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  avg_q <= '0;
    else if (en) avg_q <= avg_d;
  end

  // R4
  avg_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n) avg_q >= 0);
endmodule

// File: rtl/clkrec_cos_ref.sv
module clkrec_cos_ref #(
  parameter int DW = 16,
  parameter int TB = 14
) (
  input  logic [TB-1:0]        phase_lo,
  output logic signed [DW-1:0] ref_out
);
  localparam int HB = TB - 1;
  localparam int MW = 2*TB;
  localparam int SH = 2*HB - 2 - (DW-1);
  localparam logic [MW-1:0] MAXM = MW'(2**(DW-1) - 1);

  logic [TB-1:0]        s;
  logic [HB-1:0]        h;
  logic [MW-1:0]        pr;
  logic [MW-1:0]        magw;
  logic signed [DW-1:0] mag;

  always_comb begin
    s       = phase_lo + TB'(2**(TB-2));
    h       = s[HB-1:0];
    pr      = MW'(h) * (MW'(2**HB) - MW'(h));
    magw    = pr >> SH;
    mag     = (magw > MAXM) ? DW'(MAXM) : DW'(magw);
    ref_out = s[TB-1] ? -mag : mag;
  end
endmodule

// File: rtl/clkrec_err_fir.sv
module clkrec_err_fir
  import clkrec_pkg::*;
#(
  parameter int DW = 16,
  parameter int NT = NTAP,
  parameter int EW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] mix_in,
  output logic [NT*DW-1:0]     taps_o,
  output logic signed [EW-1:0] err_out
);
  localparam int ACCW = 2*DW + $clog2(NT) + 2;

  logic signed [DW-1:0]   tap_q [NT];
  logic signed [DW-1:0]   line  [NT];
  logic signed [ACCW-1:0] term  [NT];
  logic signed [ACCW-1:0] acc;

  for (genvar k = 0; k < NT; k++) begin : g_tap
    if (k == 0) begin : g_head
      assign line[k] = mix_in;
    end else begin : g_body
      assign line[k] = tap_q[k-1];
    end
    assign term[k] = ACCW'(FIR_C[k]) * ACCW'(line[k]);
    assign taps_o[k*DW +: DW] = tap_q[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tap_q[k] <= '0;
      else if (en) tap_q[k] <= line[k];
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NT; k++) acc = acc + term[k];
    err_out = EW'(acc >>> (DW-1));
  end

  // R6
  tap_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (tap_q[1] == $past(tap_q[0])));
endmodule

// File: rtl/clkrec_loop_nco.sv
module clkrec_loop_nco #(
  parameter int EW  = 24,
  parameter int PHW = 16,
  parameter int TB  = 14,
  parameter int INC = 1638
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic signed [EW-1:0]  err_in,
  output logic signed [PHW-1:0] phase_o,
  output logic                  stb_o
);
  localparam int SW = EW + 6;
  localparam logic signed [SW-1:0] TURN = SW'(2**TB);

  logic signed [EW-1:0]  integ_q, integ_d;
  logic signed [SW-1:0]  isum, corr, sum, ph_d;
  logic signed [PHW-1:0] phase_q;
  logic                  wrap, stb_q;

  always_comb begin
    isum    = SW'(integ_q) * SW'(15) + SW'(err_in >>> 1);
    integ_d = EW'(isum >>> 4);
    corr    = SW'(err_in >>> 6) + SW'(integ_d >>> 1);
    sum     = SW'(phase_q) + corr + SW'(INC);
    wrap    = 1'b0;
    ph_d    = sum;
    if (sum >= TURN) begin
      ph_d = sum - TURN;
      wrap = 1'b1;
    end else if (sum < -TURN) begin
      ph_d = -TURN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      phase_q <= '0;
    end else if (en) begin
      integ_q <= integ_d;
      phase_q <= PHW'(ph_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= en & wrap;
  end

  assign phase_o = phase_q;
  assign stb_o   = stb_q;

  // R9
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q < PHW'(2**TB)) && (phase_q >= -PHW'(2**TB)));
  // R9
  stb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(en));
  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(phase_q) && !stb_q));
endmodule

// File: rtl/baud_clock_recovery.sv
module baud_clock_recovery
  import clkrec_pkg::*;
#(
  parameter int DW      = 16,
  parameter int PHW     = 16,
  parameter int TB      = 14,
  parameter int NCO_INC = 1638,
  parameter int NT      = NTAP
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_vld,
  input  logic signed [DW-1:0]  smp_data,
  output logic                  baud_stb,
  output logic signed [PHW-1:0] clk_phase,
  output logic [NT*DW-1:0]      err_taps
);
  localparam int EW  = DW + 8;
  localparam int MXW = 2*DW + 3;
  localparam logic signed [MXW-1:0] MX_HI = MXW'(2**(DW-1) - 1);
  localparam logic signed [MXW-1:0] MX_LO = -MXW'(2**(DW-1));

  logic [1:0]           rst_sync;
  logic                 rst_n_s;
  logic signed [DW+2:0] dc_w;
  logic signed [DW-1:0] ref_w;
  logic signed [MXW-1:0] mix_full;
  logic signed [DW-1:0] mix_w;
  logic signed [EW-1:0] err_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  clkrec_square_dc #(.DW(DW)) u_sq (
    .clk(clk), .rst_n(rst_n_s), .en(smp_vld), .din(smp_data), .dc_out(dc_w)
  );

  clkrec_cos_ref #(.DW(DW), .TB(TB)) u_ref (
    .phase_lo(clk_phase[TB-1:0]), .ref_out(ref_w)
  );

  always_comb begin
    mix_full = (MXW'(dc_w) * MXW'(ref_w)) >>> (DW-1);
    if (mix_full > MX_HI)      mix_w = DW'(MX_HI);
    else if (mix_full < MX_LO) mix_w = DW'(MX_LO);
    else                       mix_w = DW'(mix_full);
  end

  clkrec_err_fir #(.DW(DW), .NT(NT), .EW(EW)) u_fir (
    .clk(clk), .rst_n(rst_n_s), .en(smp_vld), .mix_in(mix_w),
    .taps_o(err_taps), .err_out(err_w)
  );

  clkrec_loop_nco #(.EW(EW), .PHW(PHW), .TB(TB), .INC(NCO_INC)) u_nco (
    .clk(clk), .rst_n(rst_n_s), .en(smp_vld), .err_in(err_w),
    .phase_o(clk_phase), .stb_o(baud_stb)
  );
endmodule

// File: tb/tb_baud_clock_recovery.sv
module tb_baud_clock_recovery;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               smp_vld;
  logic signed [15:0] smp_data;
  logic               baud_stb;
  logic signed [15:0] clk_phase;
  logic [207:0]       err_taps;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    coef [13] = '{-930, -293, 732, 2571, 4769, 6557, 7249, 6557, 4769, 2571, 732, -293, -930};
  longint m_avg, m_integ, m_phase;
  longint m_tap [13];
  bit     m_wrap;

  always #10 clk = ~clk;

  baud_clock_recovery dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .baud_stb(baud_stb), .clk_phase(clk_phase), .err_taps(err_taps)
  );

  function automatic longint sat16(longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_clear();
    m_avg = 0; m_integ = 0; m_phase = 0; m_wrap = 0;
    for (int k = 0; k < 13; k++) m_tap[k] = 0;
  endtask

  // Expected behaviour built from the requirement formulas
  task automatic model_step(longint d);
    longint tone, avg_n, dc, s, h, mag, rf, mix, acc, err, integ_n, corr, sum;
    tone = (3 * d * d) >>> 15;
    if (tone > 32767) tone = 32767;
    avg_n = (7 * m_avg + tone) >>> 3;
    dc = 4 * (tone - avg_n);
    s = ((m_phase & 16383) + 4096) & 16383;
    h = s & 8191;
    mag = (h * (8192 - h)) >>> 9;
    if (mag > 32767) mag = 32767;
    rf = (s >= 8192) ? -mag : mag;
    mix = sat16((dc * rf) >>> 15);
    for (int k = 12; k > 0; k--) m_tap[k] = m_tap[k-1];
    m_tap[0] = mix;
    acc = 0;
    for (int k = 0; k < 13; k++) acc += coef[k] * m_tap[k];
    err = acc >>> 15;
    integ_n = (15 * m_integ + (err >>> 1)) >>> 4;
    corr = (err >>> 6) + (integ_n >>> 1);
    sum = m_phase + corr + 1638;
    m_wrap = 0;
    if (sum >= 16384) begin
      sum -= 16384;
      m_wrap = 1;
    end else if (sum < -16384) begin
      sum = -16384;
    end
    m_avg = avg_n; m_integ = integ_n; m_phase = sum;
  endtask

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_taps(string tag);
    int bad = -1;
    longint a;
    for (int k = 12; k >= 0; k--) begin
      a = longint'($signed(err_taps[k*16 +: 16]));
      if (a != m_tap[k]) bad = k;
    end
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s tap%0d actual=%0d expected=%0d", tag, bad,
               longint'($signed(err_taps[bad*16 +: 16])), m_tap[bad]);
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic step(bit v, longint d, string tg_tap, string tg_ph);
    bit exp_stb;
    smp_vld  = v;
    smp_data = 16'(d);
    @(posedge clk);
    exp_stb = 0;
    if (v) begin
      model_step(d);
      exp_stb = m_wrap;
    end
    @(negedge clk);
    chk_taps(tg_tap);
    chk(tg_ph, "phase", longint'(clk_phase), m_phase);
    chk(tg_ph, "strobe", longint'(baud_stb), longint'(exp_stb));
  endtask

  task automatic do_reset();
    smp_vld = 0; smp_data = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    model_clear();
  endtask

  task automatic check_reset_state();
    chk("R1", "phase", longint'(clk_phase), 0);
    chk("R1", "strobe", longint'(baud_stb), 0);
    chk("R1", "taps_zero", longint'(err_taps == '0), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nstb;
    longint prev_phase;
    void'($urandom(32'd5150));
    smp_vld = 0; smp_data = 0; rst_n = 0;
    model_clear();
    @(negedge clk);
    check_reset_state();  // R1 during reset
    do_reset();
    check_reset_state();  // R1 after release

    // R9: zero input, hand-counted wrap on the eleventh sample
    nstb = 0;
    for (int i = 1; i <= 11; i++) begin
      step(1, 0, "R6", "R9");
      if (baud_stb) nstb++;
      if (i == 10) chk("R9", "phase_before_wrap", longint'(clk_phase), 16380);
    end
    chk("R9", "phase_after_wrap", longint'(clk_phase), 1634);
    chk("R9", "strobe_count", nstb, 1);
    step(1, 0, "R6", "R9");
    chk("R9", "strobe_single_cycle", longint'(baud_stb), 0);

    // R3: full-scale negative saturates the square, mixer clamps
    do_reset();
    step(1, -32768, "R3", "R8");
    chk("R3", "tap0_saturated", longint'($signed(err_taps[15:0])), 32767);
    step(1, 32767, "R3", "R8");
    step(1, -1, "R3", "R8");
    step(1, 1, "R3", "R8");

    // R4: constant level lets the mean settle and the centred tone shrink
    for (int i = 0; i < 24; i++) step(1, 20000, "R4", "R4");
    for (int i = 0; i < 24; i++) step(1, -9000, "R4", "R4");

    // R2: stall cycles with changing data
    prev_phase = longint'(clk_phase);
    for (int i = 0; i < 8; i++) step(0, longint'($signed(16'($urandom))), "R2", "R2");
    chk("R2", "phase_unchanged", longint'(clk_phase), prev_phase);
    step(1, 12000, "R2", "R2");

    // random binary-like data with gaps
    for (int i = 0; i < 1500; i++) begin
      longint amp = longint'($urandom_range(32767, 4000));
      step(($urandom_range(3, 0) != 0), ($urandom_range(1, 0) != 0) ? amp : -amp, "R5", "R7");
    end
    for (int i = 0; i < 1500; i++) begin
      step(($urandom_range(7, 0) != 0), longint'($signed(16'($urandom))), "R6", "R8");
    end

    // R1: reset in the middle of activity
    do_reset();
    check_reset_state();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule